// File: doc/BRIEF.md
# SPI Serial Memory Command Front-End

This block is the device side of a small serial non-volatile memory reached over SPI mode 0. Each transaction is framed by an active-low chip select. The block shifts in an 8-bit opcode, most significant bit first. Depending on the opcode it then collects address bytes and data bytes, or it returns status and array contents on the serial output.

All SPI pins are treated as level inputs that are already synchronous to the system clock `clk`. The block finds SCK edges by comparing each sample with the previous one. A stopped SCK therefore holds every register, whatever level it stops at. An active-low HOLD input freezes the transfer while other devices use a shared clock. When HOLD is released, the transfer continues at the exact bit where it stopped.

Program data is first gathered in a 32-byte page buffer. Only a correctly closed transaction starts an internal timed program cycle, which copies the buffer into the on-chip array. A status/protection unit holds a program-enable latch and a two-bit protection level that locks part of the array.

Top module: `spim_front`

## Requirements
- R1: Opcode bits are sampled on rising SCK edges while chip select is low, most significant bit first. The first bit is taken on the first rising edge after chip select falls. Opcode 0x06 sets the program-enable latch and opcode 0x04 clears it.
- R2: Raising chip select before an opcode is complete discards the partial opcode, which then has no effect.
- R3: Opcode 0x05 returns the status byte and keeps repeating it for as long as chip select stays low. The status byte has bits [3:2] = protection level, bit 1 = latch, and all other bits 0. While a program cycle runs, the status byte reads 0xFF. A status read is accepted at any time.
- R4: Opcode 0x03 is followed by two address bytes, most significant bit first, of which only the low ADDR_W bits are used. The block then returns array bytes from that address. The address increments after each byte and wraps from the last location to location 0.
- R5: The serial output changes only after falling SCK edges. The output enable is low whenever chip select is high, HOLD is low, or the transaction is not in a data-return phase.
- R6: While HOLD is low, SCK edges are ignored and all transfer state is held. After HOLD is released, the transfer continues from the same bit position.
- R7: Opcode 0x02 is accepted only with the latch set. It is followed by two address bytes and then data bytes. The data bytes go into a page buffer, with the address wrapping inside its 32-byte page, and only the bytes that were sent are written. The program cycle starts when chip select rises after a whole number of bytes, one or more. The latch is cleared when the cycle ends.
- R8: A program transaction that ends with a partial data byte, or with no data byte, writes nothing and leaves the latch set.
- R9: Opcode 0x01 is accepted only with the latch set, and it takes effect only when exactly one data byte was sent. It then loads the protection level from data bits [3:2] and clears the latch. In every other case it has no effect.
- R10: The protection levels are 0 (nothing locked), 1 (top quarter locked), 2 (top half locked) and 3 (whole array locked). A program command whose start address lies in a locked region writes nothing.
- R11: While a program cycle runs, every opcode except the status read is ignored.
- R12: An unrecognised opcode makes the block ignore all further bits until chip select goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all SPI pins are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from the master (mode 0) |
| cs_n | input | 1 | Active-low chip select that frames a transaction |
| hold_n | input | 1 | Active-low pause of the current transfer |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out |
| so_en | output | 1 | Drive enable for the SO pad; when low the pad is high-impedance |

## Verification
The checker watches several rules on every clock. It checks that the output enable stays low while chip select is high or HOLD is low. It checks that the bit counter and phase do not move during HOLD, and that an ignored transaction stays ignored until deselect. It checks that no address or data phase can open during a program cycle, that a cycle starts only with the latch set, and that the latch is clear once the cycle ends. Other behaviours can only be shown by the bench scenarios against its behavioural memory model. These are the byte contents and their auto-increment wrap, page-wrapped and partial-page programming, the discarding of malformed or locked programs, the exact-one-byte rule for status writes, and the resumption of a read after HOLD.

// File: rtl/spim_pkg.sv
package spim_pkg;
   typedef enum logic [7:0] {
      OP_ARM        = 8'h06,
      OP_DISARM     = 8'h04,
      OP_STAT_RD    = 8'h05,
      OP_STAT_WR    = 8'h01,
      OP_ARRAY_RD   = 8'h03,
      OP_ARRAY_PROG = 8'h02
   } opc_e;

   typedef enum logic [2:0] {
      PH_OPC,
      PH_ADDR,
      PH_RDATA,
      PH_STAT,
      PH_WDATA,
      PH_SKIP
   } phase_e;

   localparam int PAGE_BYTES = 32;
endpackage

// File: rtl/spim_edge.sv
module spim_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic sck,
   input  logic cs_n,
   input  logic hold_n,
   output logic live,
   output logic sck_rise,
   output logic sck_fall,
   output logic cs_end
);
   logic sck_q, cs_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_q <= 1'b0;
         cs_q  <= 1'b1;
      end else begin
         sck_q <= sck;
         cs_q  <= cs_n;
      end
   end

   assign live     = !cs_n && hold_n;
   assign sck_rise = live && sck && !sck_q;
   assign sck_fall = live && !sck && sck_q;
   assign cs_end   = cs_n && !cs_q;
endmodule

// File: rtl/spim_guard.sv
module spim_guard #(
   parameter bit LOCK_EN = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       arm,
   input  logic       disarm,
   input  logic       wr_stat,
   input  logic [1:0] wr_val,
   input  logic       prog_done,
   input  logic [1:0] chk_top,
   output logic       latch,
   output logic [1:0] lock,
   output logic       locked
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latch <= 1'b0;
         lock  <= 2'd0;
      end else if (wr_stat) begin
         lock  <= wr_val;
         latch <= 1'b0;
      end else if (prog_done || disarm) begin
         latch <= 1'b0;
      end else if (arm) begin
         latch <= 1'b1;
      end
   end

   generate
      if (LOCK_EN) begin : g_lock
         always_comb begin
            unique case (lock)
               2'd0:    locked = 1'b0;
               2'd1:    locked = &chk_top;
               2'd2:    locked = chk_top[1];
               default: locked = 1'b1;
            endcase
         end
      end else begin : g_nolock
         assign locked = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/spim_store.sv
module spim_store #(
   parameter int ADDR_W      = 10,
   parameter int PROG_CYCLES = 400
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic [ADDR_W-1:0]                      rd_addr,
   output logic [7:0]                             rd_data,
   input  logic                                   buf_clr,
   input  logic                                   buf_we,
   input  logic [$clog2(spim_pkg::PAGE_BYTES)-1:0] buf_idx,
   input  logic [7:0]                             buf_data,
   input  logic                                   start,
   input  logic [ADDR_W-$clog2(spim_pkg::PAGE_BYTES)-1:0] page,
   output logic                                   busy,
   output logic                                   done
);
   localparam int PB     = spim_pkg::PAGE_BYTES;
   localparam int PIDX_W = $clog2(PB);
   localparam int DEPTH  = 1 << ADDR_W;
   localparam int TMR_W  = $clog2(PROG_CYCLES);

   logic [7:0]               mem  [DEPTH];
   logic [7:0]               pbuf [PB];
   logic [PB-1:0]            pmask;
   logic [TMR_W-1:0]         tmr;
   logic [ADDR_W-PIDX_W-1:0] page_q;
   logic [PIDX_W-1:0]        widx;
   logic                     wphase;

   assign rd_data = mem[rd_addr];
   assign done    = busy && (tmr == TMR_W'(PROG_CYCLES - 1));
   assign widx    = tmr[PIDX_W-1:0];
   assign wphase  = busy && (tmr < TMR_W'(PB));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         tmr    <= '0;
         page_q <= '0;
         pmask  <= '0;
      end else begin
         if (buf_clr)     pmask <= '0;
         else if (buf_we) pmask[buf_idx] <= 1'b1;
         if (start) begin
            busy   <= 1'b1;
            tmr    <= '0;
            page_q <= page;
         end else if (busy) begin
            tmr <= tmr + 1'b1;
            if (done) busy <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (buf_we) pbuf[buf_idx] <= buf_data;
      if (wphase && pmask[widx]) mem[{page_q, widx}] <= pbuf[widx];
   end
endmodule

// File: rtl/spim_front.sv
module spim_front #(
   parameter int ADDR_W      = 10,
   parameter int PROG_CYCLES = 400,
   parameter bit LOCK_EN     = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sck,
   input  logic cs_n,
   input  logic hold_n,
   input  logic si,
   output logic so,
   output logic so_en
);
   import spim_pkg::*;

   localparam int ADDR_BYTES = (ADDR_W + 7) / 8;
   localparam int AB_W       = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
   localparam int PIDX_W     = $clog2(PAGE_BYTES);

   generate
      if (ADDR_W < PIDX_W + 2 || ADDR_W > 16) begin : g_bad_addr_w
         $error("spim_front: ADDR_W out of range");
      end
      if (PROG_CYCLES <= PAGE_BYTES) begin : g_bad_prog_cycles
         $error("spim_front: PROG_CYCLES must exceed the page size");
      end
   endgenerate

   logic              live, sck_rise, sck_fall, cs_end;
   logic              latch, locked, busy, done;
   logic [1:0]        lock;
   phase_e            ph;
   logic [2:0]        cnt;
   logic [6:0]        ish;
   logic [ADDR_W-2:0] asr;
   logic [AB_W-1:0]   abyte;
   logic              is_prog;
   logic [ADDR_W-1:0] addr, rd_addr;
   logic [PIDX_W-1:0] ptr;
   logic [1:0]        nbytes;
   logic [7:0]        txb, rd_data, stat_byte, ibyte;
   logic [ADDR_W-1:0] naddr;
   logic              so_q, byte_end;
   logic              arm, disarm, wr_stat, start, buf_we, buf_clr;

   spim_edge u_edge (
      .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .hold_n(hold_n),
      .live(live), .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_end(cs_end)
   );

   assign ibyte     = {ish, si};
   assign naddr     = {asr, si};
   assign byte_end  = sck_rise && (cnt == 3'd7);
   assign stat_byte = busy ? 8'hFF : {4'b0000, lock, latch, 1'b0};
   assign rd_addr   = (ph == PH_ADDR) ? naddr : addr + 1'b1;

   assign arm     = byte_end && ph == PH_OPC && ibyte == OP_ARM && !busy;
   assign disarm  = byte_end && ph == PH_OPC && ibyte == OP_DISARM && !busy;
   assign buf_clr = byte_end && ph == PH_OPC && ibyte == OP_ARRAY_PROG && latch && !busy;
   assign buf_we  = byte_end && ph == PH_WDATA && is_prog;
   assign wr_stat = cs_end && ph == PH_WDATA && !is_prog && cnt == 3'd0 && nbytes == 2'd1;
   assign start   = cs_end && ph == PH_WDATA && is_prog && cnt == 3'd0 &&
                    nbytes != 2'd0 && !locked;

   spim_guard #(.LOCK_EN(LOCK_EN)) u_guard (
      .clk(clk), .rst_n(rst_n), .arm(arm), .disarm(disarm),
      .wr_stat(wr_stat), .wr_val(ish[3:2]), .prog_done(done),
      .chk_top(addr[ADDR_W-1 -: 2]), .latch(latch), .lock(lock), .locked(locked)
   );

   spim_store #(.ADDR_W(ADDR_W), .PROG_CYCLES(PROG_CYCLES)) u_store (
      .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_data(rd_data),
      .buf_clr(buf_clr), .buf_we(buf_we), .buf_idx(ptr), .buf_data(ibyte),
      .start(start), .page(addr[ADDR_W-1:PIDX_W]), .busy(busy), .done(done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph      <= PH_OPC;
         cnt     <= 3'd0;
         ish     <= '0;
         asr     <= '0;
         abyte   <= '0;
         is_prog <= 1'b0;
         addr    <= '0;
         ptr     <= '0;
         nbytes  <= 2'd0;
         txb     <= 8'h00;
      end else if (cs_n) begin
         ph     <= PH_OPC;
         cnt    <= 3'd0;
         abyte  <= '0;
         nbytes <= 2'd0;
      end else if (sck_rise) begin
         cnt <= cnt + 3'd1;
         ish <= ibyte[6:0];
         unique case (ph)
            PH_OPC: if (cnt == 3'd7) begin
               ph <= PH_SKIP;
               if (ibyte == OP_STAT_RD) begin
                  ph  <= PH_STAT;
                  txb <= stat_byte;
               end else if (!busy) begin
                  if (ibyte == OP_ARRAY_RD) begin
                     ph <= PH_ADDR;
                     is_prog <= 1'b0;
                  end else if (ibyte == OP_ARRAY_PROG && latch) begin
                     ph <= PH_ADDR;
                     is_prog <= 1'b1;
                  end else if (ibyte == OP_STAT_WR && latch) begin
                     ph <= PH_WDATA;
                     is_prog <= 1'b0;
                  end
               end
            end
            PH_ADDR: begin
               asr <= naddr[ADDR_W-2:0];
               if (cnt == 3'd7) begin
                  abyte <= abyte + 1'b1;
                  if (abyte == AB_W'(ADDR_BYTES - 1)) begin
                     addr <= naddr;
                     ptr  <= naddr[PIDX_W-1:0];
                     txb  <= rd_data;
                     ph   <= is_prog ? PH_WDATA : PH_RDATA;
                  end
               end
            end
            PH_RDATA: if (cnt == 3'd7) begin
               addr <= addr + 1'b1;
               txb  <= rd_data;
            end
            PH_STAT: if (cnt == 3'd7) txb <= stat_byte;
            PH_WDATA: if (cnt == 3'd7) begin
               ptr <= ptr + 1'b1;
               if (nbytes != 2'd3) nbytes <= nbytes + 2'd1;
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        so_q <= 1'b0;
      else if (sck_fall) so_q <= txb[3'd7 - cnt];
   end

   assign so    = so_q;
   assign so_en = live && (ph == PH_RDATA || ph == PH_STAT);
endmodule

// File: rtl/spim_front_chk.sv
module spim_front_chk (
   input logic             clk,
   input logic             rst_n,
   input logic             cs_n,
   input logic             hold_n,
   input logic             so_en,
   input spim_pkg::phase_e ph,
   input logic [2:0]       cnt,
   input logic             busy,
   input logic             latch
);
   import spim_pkg::*;

   AST_SO_QUIET_DESELECT: assert property (@(posedge clk) disable iff (!rst_n) (cs_n || !hold_n) |-> !so_en); // R5
   AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n) (!hold_n && !cs_n) |=> ($stable(cnt) && $stable(ph))); // R6
   AST_START_NEEDS_LATCH: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(latch)); // R7
   AST_DONE_CLEARS_LATCH: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> !latch); // R7
   AST_BUSY_BLOCKS_CMD: assert property (@(posedge clk) disable iff (!rst_n) busy |-> !(ph == PH_ADDR || ph == PH_WDATA)); // R11
   AST_SKIP_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (ph == PH_SKIP && !cs_n) |=> ph == PH_SKIP); // R12
endmodule

bind spim_front spim_front_chk chk_i (
   .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .hold_n(hold_n), .so_en(so_en),
   .ph(ph), .cnt(cnt), .busy(busy), .latch(latch)
);

// File: tb/spim_front_tb_top.sv
module spim_front_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int AW         = 10;

   logic clk = 1'b0, rst_n = 1'b0;
   logic sck = 1'b0, cs_n = 1'b1, hold_n = 1'b1, si = 1'b0;
   logic so, so_en;
   int   n_cmp = 0, n_bad = 0;

   logic [7:0] mem_m [1 << AW];
   logic       latch_m = 1'b0;
   logic [1:0] lock_m  = 2'd0;
   logic [7:0] dq [$];
   logic [7:0] rx;

   always #(CLK_PERIOD / 2) clk = ~clk;

   spim_front dut_i (
      .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .hold_n(hold_n),
      .si(si), .so(so), .so_en(so_en)
   );

   task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] stat_m();
      return {4'b0000, lock_m, latch_m, 1'b0};
   endfunction

   function automatic bit lk(input logic [AW-1:0] a);
      case (lock_m)
         2'd0:    return 1'b0;
         2'd1:    return a[AW-1:AW-2] == 2'b11;
         2'd2:    return a[AW-1];
         default: return 1'b1;
      endcase
   endfunction

   task automatic sel();
      @(negedge clk) cs_n = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic desel();
      @(negedge clk) sck = 1'b0;
      repeat (2) @(negedge clk);
      cs_n = 1'b1;
      repeat (3) @(negedge clk);
   endtask

   // One byte (or its top nbits) on the bus; so_en compared with drv at every bit.
   task automatic xfer(input logic [7:0] tx, input bit drv, output logic [7:0] r,
                       input string req, input int hb = -1, input int nbits = 8);
      r = 8'h00;
      for (int i = 7; i >= 8 - nbits; i--) begin
         @(negedge clk) begin sck = 1'b0; si = tx[i]; end
         repeat (2) @(negedge clk);
         if (i == hb) begin
            hold_n = 1'b0;
            repeat (2) @(negedge clk);
            check(so_en == 1'b0, "R5 hold quiets SO", {7'd0, so_en}, 8'h00);
            for (int t = 0; t < 3; t++) begin
               sck = 1'b1; si = ~si; repeat (2) @(negedge clk);
               sck = 1'b0; repeat (2) @(negedge clk);
            end
            si = tx[i];
            hold_n = 1'b1;
            repeat (2) @(negedge clk);
         end
         r[i] = so;
         check(so_en == drv, req, {7'd0, so_en}, {7'd0, drv});
         sck = 1'b1;
         repeat (2) @(negedge clk);
      end
   endtask

   task automatic simple(input logic [7:0] op, input string req);
      sel(); xfer(op, 1'b0, rx, req); desel();
   endtask

   task automatic stat_chk(input logic [7:0] exp, input string req);
      sel();
      xfer(8'h05, 1'b0, rx, req);
      for (int k = 0; k < 2; k++) begin
         xfer(8'h00, 1'b1, rx, req);
         check(rx == exp, req, rx, exp);
      end
      desel();
   endtask

   task automatic wait_ready(input string req);
      logic [7:0] fin;
      bit         seen;
      fin  = stat_m();
      seen = 1'b0;
      sel();
      xfer(8'h05, 1'b0, rx, req);
      xfer(8'h00, 1'b1, rx, req);
      check(rx == 8'hFF, "R3 status during program cycle", rx, 8'hFF);
      for (int k = 0; k < 40 && !seen; k++) begin
         xfer(8'h00, 1'b1, rx, req);
         if (rx == fin) seen = 1'b1;
         else check(rx == 8'hFF, "R3 status while busy", rx, 8'hFF);
      end
      check(seen, req, rx, fin);
      desel();
   endtask

   task automatic prog(input logic [AW-1:0] a, input int tail, input bit do_wait, input string req);
      sel();
      xfer(8'h02, 1'b0, rx, req);
      xfer({6'd0, a[AW-1:8]}, 1'b0, rx, req);
      xfer(a[7:0], 1'b0, rx, req);
      foreach (dq[k]) xfer(dq[k], 1'b0, rx, req);
      if (tail > 0) xfer(8'hC9, 1'b0, rx, req, -1, tail);
      desel();
      if (latch_m && !lk(a) && dq.size() > 0 && tail == 0) begin
         foreach (dq[k]) mem_m[{a[AW-1:5], 5'(a[4:0] + 5'(k))}] = dq[k];
         latch_m = 1'b0;
         if (do_wait) wait_ready(req);
      end
   endtask

   task automatic rd_chk(input logic [AW-1:0] a, input int n, input string req,
                         input int hbyte = -1, input int hbit = -1);
      sel();
      xfer(8'h03, 1'b0, rx, req);
      xfer({6'd0, a[AW-1:8]}, 1'b0, rx, req);
      xfer(a[7:0], 1'b0, rx, req);
      for (int k = 0; k < n; k++) begin
         logic [AW-1:0] ea;
         ea = a + AW'(k);
         xfer(8'h00, 1'b1, rx, req, (k == hbyte) ? hbit : -1);
         check(rx == mem_m[ea], req, rx, mem_m[ea]);
      end
      desel();
   endtask

   task automatic stat_wr(input logic [7:0] v, input int nb, input string req);
      sel();
      xfer(8'h01, 1'b0, rx, req);
      for (int k = 0; k < nb; k++) xfer(v, 1'b0, rx, req);
      desel();
      if (latch_m && nb == 1) begin
         lock_m  = v[3:2];
         latch_m = 1'b0;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check(so_en == 1'b0, "R5 reset SO quiet", {7'd0, so_en}, 8'h00);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      stat_chk(8'h00, "R3 reset status");

      // R2: partial opcode aborted by deselect
      sel(); xfer(8'h06, 1'b0, rx, "R2 partial", -1, 5); desel();
      stat_chk(stat_m(), "R2 aborted opcode");

      // R12: unknown opcode swallows the rest of the transaction
      sel(); xfer(8'hAB, 1'b0, rx, "R12"); xfer(8'h06, 1'b0, rx, "R12"); desel();
      stat_chk(stat_m(), "R12 unknown opcode ignored");

      // R1: enable and disable latch
      simple(8'h06, "R1 arm"); latch_m = 1'b1;
      stat_chk(stat_m(), "R1 latch set");
      simple(8'h04, "R1 disarm"); latch_m = 1'b0;
      stat_chk(stat_m(), "R1 latch cleared");

      // R7: programming, partial page mask and page wrap
      simple(8'h06, "R7"); latch_m = 1'b1;
      dq = {8'hA1, 8'hA2, 8'hA3, 8'hA4};
      prog(10'h3E0, 0, 1'b1, "R7 program page");
      stat_chk(stat_m(), "R7 latch cleared after cycle");
      simple(8'h06, "R7"); latch_m = 1'b1;
      dq = {8'h11, 8'h22, 8'h33, 8'h44};
      prog(10'h01E, 0, 1'b1, "R7 page wrap program");
      rd_chk(10'h000, 2, "R7 page wrap read");
      simple(8'h06, "R7"); latch_m = 1'b1;
      dq = {8'h5A, 8'h5B};
      prog(10'h3FE, 0, 1'b1, "R7 tail of page");
      rd_chk(10'h3E0, 4, "R7 unsent bytes kept");
      rd_chk(10'h3FE, 4, "R4 read wrap at array end");

      // R6: HOLD in the middle of a read byte
      rd_chk(10'h3E0, 3, "R6 hold resume", 1, 3);

      // R8: malformed programs are dropped
      simple(8'h06, "R8"); latch_m = 1'b1;
      dq = {8'h77};
      prog(10'h3E0, 4, 1'b1, "R8 partial byte");
      stat_chk(stat_m(), "R8 no cycle latch kept");
      dq = {};
      prog(10'h3E0, 0, 1'b1, "R8 no data");
      stat_chk(stat_m(), "R8 empty program");
      rd_chk(10'h3E0, 1, "R8 array unchanged");

      // R11: read ignored during program cycle
      dq = {8'hC3};
      prog(10'h100, 0, 1'b0, "R11 start cycle");
      sel();
      xfer(8'h03, 1'b0, rx, "R11"); xfer(8'h03, 1'b0, rx, "R11"); xfer(8'hE0, 1'b0, rx, "R11");
      xfer(8'h00, 1'b0, rx, "R11 read blocked while busy");
      desel();
      wait_ready("R11 cycle completes");
      rd_chk(10'h100, 1, "R11 programmed byte");

      // R9: status write rules
      stat_wr(8'h0C, 1, "R9 without latch");
      stat_chk(stat_m(), "R9 ignored without latch");
      simple(8'h06, "R9"); latch_m = 1'b1;
      stat_wr(8'h04, 1, "R9 write level 1");
      stat_chk(stat_m(), "R9 level loaded latch cleared");

      // R10: protection levels
      simple(8'h06, "R10"); latch_m = 1'b1;
      dq = {8'h00};
      prog(10'h3E0, 0, 1'b1, "R10 locked quarter");
      stat_chk(stat_m(), "R10 no cycle in locked region");
      rd_chk(10'h3E0, 1, "R10 locked byte kept");
      dq = {8'h5C};
      prog(10'h100, 0, 1'b1, "R10 unlocked region");
      rd_chk(10'h100, 1, "R10 unlocked byte written");
      simple(8'h06, "R10"); latch_m = 1'b1;
      stat_wr(8'h0C, 1, "R10 lock all");
      simple(8'h06, "R10"); latch_m = 1'b1;
      dq = {8'hEE};
      prog(10'h000, 0, 1'b1, "R10 whole array locked");
      rd_chk(10'h000, 1, "R10 bottom byte kept");
      stat_wr(8'h00, 2, "R9 two data bytes");
      stat_chk(stat_m(), "R9 two bytes ignored");

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule